// File: doc/BRIEF.md
# Edge-Captured SMI/SCI Status Register

This block is a 32-bit status register in the configuration space of a PCI Express root port. It records system-management interrupt (SMI) and system-control interrupt (SCI) events. Event flags from the hot-plug controller and the power-management event logic are sampled on every clock. A rising edge on a flag, gated by the enable that belongs to it, sets a sticky status bit. Status bits stay set until software writes a one to them through a plain write port with byte enables. The whole register value is visible on a read-data output at all times.

Two level outputs come from the latched bits. The SMI request is active while any of the five SMI status bits is set. The SCI request is active while either of the two SCI status bits is set. Both requests fall once software has cleared every bit that feeds them. The register sits at configuration offset DCh. Decoding of that offset is done above this block, which only sees the write strobe.

Top module: `smiSciStatusReg`

## Requirements
- R1: After reset, `rdData` is 32'h0000_0000 and `smiReq` and `sciReq` are 0.
- R2: With `hpSmiEn` = 1, a 0-to-1 transition is captured one clock edge after it is sampled, in the following bits:
  - bit 4 for `evtLinkActChg`
  - bit 3 for `evtCmdDone`
  - bit 2 for `evtAttnBtn`
  - bit 1 for `evtPresChg`
- R3: A flag sets no bit when:
  - its enable is 0;
  - it stays high across cycles (only a transition counts); or
  - it is already high when reset is released.
- R4: A 0-to-1 transition of `evtPmeStat` while `pmSmiEn` = 1 sets bit 0.
- R5: A 0-to-1 transition of `pmSciNeed` sets bit 31. A 0-to-1 transition of `hpSciNeed` sets bit 30. Neither has an enable.
- R6: A write with `wrEn` = 1 clears every implemented bit n for which `wrData[n]` = 1 and `wrBe[n/8]` = 1. Bits written with 0, and bits in bytes whose enable is 0, keep their value.
- R7: If an event edge and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R8: Bits 29:5 always read as 0, whatever is written.
- R9: `smiReq` is the OR of bits 4:0 and `sciReq` is the OR of bits 31:30. Both are level signals that only fall after a clearing write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| evtLinkActChg | input | 1 | Hot-plug link-active-state-changed flag |
| evtCmdDone | input | 1 | Hot-plug command-completed flag |
| evtAttnBtn | input | 1 | Hot-plug attention-button-pressed flag |
| evtPresChg | input | 1 | Hot-plug presence-detect-changed flag |
| evtPmeStat | input | 1 | PME status flag |
| hpSciNeed | input | 1 | Hot-plug controller needs an SCI |
| pmSciNeed | input | 1 | PME logic needs an SCI |
| hpSmiEn | input | 1 | Enable for hot-plug SMI capture |
| pmSmiEn | input | 1 | Enable for power-management SMI capture |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 32 | Write data, ones clear bits |
| wrBe | input | 4 | Byte enables for the write |
| rdData | output | 32 | Current register value |
| smiReq | output | 1 | SMI request level |
| sciReq | output | 1 | SCI request level |

## Verification
The bench builds the block with its single default configuration of seven event sources. That configuration is small enough to sweep in full:
- every source against both enable settings;
- every one of the 16 byte-enable masks against a fully set register;
- a write-versus-edge collision on each source.

Expected register words are formed in the bench from the bit positions given in the requirements. This makes every combination of set, clear, masking and request level reachable.

// File: rtl/smiSciPkg.sv
package smiSciPkg;

  localparam int REG_W   = 32;
  localparam int BYTE_W  = 8;
  localparam int BE_W    = REG_W / BYTE_W;
  localparam int NUM_SRC = 7;

  // source index order used throughout the block
  typedef enum int {
    SRC_PME      = 0,
    SRC_PRES     = 1,
    SRC_ATTN     = 2,
    SRC_CMD      = 3,
    SRC_LINK     = 4,
    SRC_HP_SCI   = 5,
    SRC_PM_SCI   = 6
  } srcIdxE;

  // register bit position of each source; neighbours decode these
  function automatic int srcBitPos(input int idx);
    case (idx)
      SRC_PME:    return 0;
      SRC_PRES:   return 1;
      SRC_ATTN:   return 2;
      SRC_CMD:    return 3;
      SRC_LINK:   return 4;
      SRC_HP_SCI: return 30;
      default:    return 31;
    endcase
  endfunction

  function automatic bit srcIsSci(input int idx);
    return (idx == SRC_HP_SCI) || (idx == SRC_PM_SCI);
  endfunction

  typedef struct packed {
    logic [NUM_SRC-1:0] setStb;
    logic [NUM_SRC-1:0] clrStb;
  } strobeT;

endpackage

// File: rtl/smiSciCtrl.sv
module smiSciCtrl
  import smiSciPkg::*;
#(
  parameter int NSRC = NUM_SRC,
  parameter int DW   = REG_W,
  localparam int BEW = DW / BYTE_W
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [NSRC-1:0] srcFlag,
  input  logic [NSRC-1:0] srcEn,
  input  logic            wrEn,
  input  logic [DW-1:0]   wrData,
  input  logic [BEW-1:0]  wrBe,
  output strobeT          stb
);

  logic [NSRC-1:0] prevFlag;
  logic            armed;
  logic [NSRC-1:0] setVec;
  logic [NSRC-1:0] clrVec;

  // registered copy of every flag; armed gates the first cycle after reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevFlag <= '0;
      armed    <= 1'b0;
    end else begin
      prevFlag <= srcFlag;
      armed    <= 1'b1;
    end
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    localparam int POS = srcBitPos(i);
    localparam int BYT = POS / BYTE_W;

    assign setVec[i] = armed & srcEn[i] & srcFlag[i] & ~prevFlag[i];
    assign clrVec[i] = wrEn & wrBe[BYT] & wrData[POS];

    // R3
    no_level_retrigger_chk: assert property (@(posedge clk) disable iff (!rstN)
      (srcFlag[i] && $past(srcFlag[i])) |-> !setVec[i]);

    // R3
    enable_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
      !srcEn[i] |-> !setVec[i]);
  end

  always_comb begin
    stb.setStb = setVec;
    stb.clrStb = clrVec;
  end

endmodule

// File: rtl/smiSciDatapath.sv
module smiSciDatapath
  import smiSciPkg::*;
#(
  parameter int NSRC = NUM_SRC,
  parameter int DW   = REG_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobeT        stb,
  output logic [DW-1:0] rdData,
  output logic          smiReq,
  output logic          sciReq
);

  logic [NSRC-1:0] statusQ;
  logic [NSRC-1:0] smiMask;
  logic [NSRC-1:0] sciMask;

  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                statusQ[i] <= 1'b0;
      else if (stb.setStb[i])   statusQ[i] <= 1'b1;
      else if (stb.clrStb[i])   statusQ[i] <= 1'b0;
    end

    assign sciMask[i] = srcIsSci(i);
    assign smiMask[i] = !srcIsSci(i);

    // R7
    set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
      stb.setStb[i] |=> statusQ[i]);

    // R6
    clear_takes_chk: assert property (@(posedge clk) disable iff (!rstN)
      (stb.clrStb[i] && !stb.setStb[i]) |=> !statusQ[i]);

    // R6
    hold_value_chk: assert property (@(posedge clk) disable iff (!rstN)
      (!stb.clrStb[i] && !stb.setStb[i]) |=> (statusQ[i] == $past(statusQ[i])));
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NSRC; i++) begin
      rdData[srcBitPos(i)] = statusQ[i];
    end
  end

  assign smiReq = |(statusQ & smiMask);
  assign sciReq = |(statusQ & sciMask);

endmodule

// File: rtl/smiSciStatusReg.sv
module smiSciStatusReg
  import smiSciPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        evtLinkActChg,
  input  logic        evtCmdDone,
  input  logic        evtAttnBtn,
  input  logic        evtPresChg,
  input  logic        evtPmeStat,
  input  logic        hpSciNeed,
  input  logic        pmSciNeed,
  input  logic        hpSmiEn,
  input  logic        pmSmiEn,
  input  logic        wrEn,
  input  logic [31:0] wrData,
  input  logic [3:0]  wrBe,
  output logic [31:0] rdData,
  output logic        smiReq,
  output logic        sciReq
);

  logic [NUM_SRC-1:0] srcFlag;
  logic [NUM_SRC-1:0] srcEn;
  strobeT             stb;

  always_comb begin
    srcFlag             = '0;
    srcFlag[SRC_PME]    = evtPmeStat;
    srcFlag[SRC_PRES]   = evtPresChg;
    srcFlag[SRC_ATTN]   = evtAttnBtn;
    srcFlag[SRC_CMD]    = evtCmdDone;
    srcFlag[SRC_LINK]   = evtLinkActChg;
    srcFlag[SRC_HP_SCI] = hpSciNeed;
    srcFlag[SRC_PM_SCI] = pmSciNeed;

    srcEn               = '1;
    srcEn[SRC_PME]      = pmSmiEn;
    srcEn[SRC_PRES]     = hpSmiEn;
    srcEn[SRC_ATTN]     = hpSmiEn;
    srcEn[SRC_CMD]      = hpSmiEn;
    srcEn[SRC_LINK]     = hpSmiEn;
  end

  smiSciCtrl #(.NSRC(NUM_SRC), .DW(REG_W)) ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .srcFlag(srcFlag),
    .srcEn  (srcEn),
    .wrEn   (wrEn),
    .wrData (wrData),
    .wrBe   (wrBe),
    .stb    (stb)
  );

  smiSciDatapath #(.NSRC(NUM_SRC), .DW(REG_W)) dp_i (
    .clk   (clk),
    .rstN  (rstN),
    .stb   (stb),
    .rdData(rdData),
    .smiReq(smiReq),
    .sciReq(sciReq)
  );

  // R9
  smi_drop_on_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(smiReq) |-> $past(wrEn));

  // R9
  sci_drop_on_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sciReq) |-> $past(wrEn));

endmodule

// File: tb/smiSciStatusReg_tb_top.sv
module smiSciStatusReg_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        evtLinkActChg = 0, evtCmdDone = 0, evtAttnBtn = 0, evtPresChg = 0;
  logic        evtPmeStat = 0, hpSciNeed = 0, pmSciNeed = 0;
  logic        hpSmiEn = 0, pmSmiEn = 0;
  logic        wrEn = 0;
  logic [31:0] wrData = '0;
  logic [3:0]  wrBe = '0;
  logic [31:0] rdData;
  logic        smiReq, sciReq;

  int nVec = 0;
  int nBad = 0;

  localparam logic [31:0] ALL_BITS = 32'hC000_001F;

  always #2 clk = ~clk;

  smiSciStatusReg dut_i (.*);

  // bit position of source k, taken from R2, R4, R5
  function automatic int posOf(input int k);
    case (k)
      0: return 0;  1: return 1;  2: return 2;  3: return 3;
      4: return 4;  5: return 30; default: return 31;
    endcase
  endfunction

  function automatic string reqOf(input int k);
    if (k == 0) return "R4";
    if (k >= 5) return "R5";
    return "R2";
  endfunction

  task automatic setFlag(input int k, input logic v);
    case (k)
      0: evtPmeStat = v;  1: evtPresChg = v;   2: evtAttnBtn = v;
      3: evtCmdDone = v;  4: evtLinkActChg = v; 5: hpSciNeed = v;
      default: pmSciNeed = v;
    endcase
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic checkAll(input string req, input logic [31:0] exp);
    logic expSmi, expSci;
    expSmi = |exp[4:0];
    expSci = |exp[31:30];
    nVec++;
    if (rdData !== exp || smiReq !== expSmi || sciReq !== expSci) begin
      nBad++;
      $display("FAIL %s: rdData=%h smi=%b sci=%b expected rdData=%h smi=%b sci=%b",
               req, rdData, smiReq, sciReq, exp, expSmi, expSci);
    end
  endtask

  task automatic clearAll();
    wrEn = 1; wrData = '1; wrBe = 4'hF;
    tick();
    wrEn = 0; wrData = '0; wrBe = 4'h0;
  endtask

  task automatic setEverything();
    hpSmiEn = 1; pmSmiEn = 1;
    for (int k = 0; k < 7; k++) setFlag(k, 1);
    tick();
    for (int k = 0; k < 7; k++) setFlag(k, 0);
    tick();
  endtask

  initial begin
    #400000;
    nBad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    // R1 and R3: a flag high before reset release must not count
    evtPresChg = 1; hpSmiEn = 1;
    tick(); tick();
    rstN = 1;
    checkAll("R1", 32'h0);
    tick(); tick(); tick();
    checkAll("R3 flag high at reset release", 32'h0);
    evtPresChg = 0; hpSmiEn = 0;
    tick();
    checkAll("R3", 32'h0);

    // per-source sweep against both enable settings
    for (int k = 0; k < 7; k++) begin
      for (int en = 0; en < 2; en++) begin
        logic [31:0] exp;
        hpSmiEn = en[0]; pmSmiEn = en[0];
        setFlag(k, 1);
        tick();
        exp = (en == 1 || k >= 5) ? (32'h1 << posOf(k)) : 32'h0;
        checkAll(en == 0 && k < 5 ? "R3 disabled source" : reqOf(k), exp);
        // R6 clear while the flag is still held high; R3 no retrigger on level
        wrEn = 1; wrData = '1; wrBe = 4'hF;
        tick();
        wrEn = 0; wrData = '0; wrBe = 4'h0;
        checkAll("R6", 32'h0);
        tick();
        checkAll("R3 held level", 32'h0);
        setFlag(k, 0);
        tick();
      end
    end

    // R6: every byte-enable mask against a fully set register
    for (int m = 0; m < 16; m++) begin
      logic [31:0] keep;
      setEverything();
      checkAll("R6 setup", ALL_BITS);
      keep = 32'h0;
      for (int b = 0; b < 4; b++) if (!m[b]) keep[b*8 +: 8] = 8'hFF;
      // writing zeros with all bytes enabled changes nothing
      wrEn = 1; wrData = '0; wrBe = 4'hF;
      tick();
      checkAll("R6 zero write", ALL_BITS);
      wrData = '1; wrBe = m[3:0];
      tick();
      wrEn = 0; wrData = '0; wrBe = 4'h0;
      checkAll("R6 byte mask", ALL_BITS & keep);
      clearAll();
    end

    // R6: clear single bits one at a time
    setEverything();
    begin
      logic [31:0] exp;
      exp = ALL_BITS;
      for (int k = 0; k < 7; k++) begin
        wrEn = 1; wrData = 32'h1 << posOf(k); wrBe = 4'hF;
        tick();
        wrEn = 0;
        exp[posOf(k)] = 1'b0;
        checkAll("R6 single bit clear", exp);
      end
    end

    // R7: edge and clearing write on the same bit in the same cycle
    hpSmiEn = 1; pmSmiEn = 1;
    for (int k = 0; k < 7; k++) begin
      setFlag(k, 1);
      wrEn = 1; wrData = '1; wrBe = 4'hF;
      tick();
      wrEn = 0; wrData = '0; wrBe = 4'h0;
      checkAll("R7", 32'h1 << posOf(k));
      setFlag(k, 0);
      clearAll();
    end

    // R8: reserved bits read zero after a write of ones
    setEverything();
    wrEn = 1; wrData = 32'h3FFF_FFE0; wrBe = 4'hF;
    tick();
    wrEn = 0;
    checkAll("R8", ALL_BITS);
    nVec++;
    if (rdData[29:5] !== '0) begin
      nBad++;
      $display("FAIL R8: reserved=%h expected=0", rdData[29:5]);
    end

    // R9: SMI and SCI requests follow their own groups
    clearAll();
    setFlag(2, 1); tick(); setFlag(2, 0); tick();
    checkAll("R9 smi only", 32'h4);
    setFlag(5, 1); tick(); setFlag(5, 0); tick();
    checkAll("R9 both", 32'h4000_0004);
    wrEn = 1; wrData = 32'h0000_0004; wrBe = 4'h1; tick(); wrEn = 0;
    checkAll("R9 sci only", 32'h4000_0000);
    clearAll();
    checkAll("R9 none", 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

endmodule